// File: doc/BRIEF.md
# CAN Message Object Manager

This block keeps fifteen CAN message objects on behalf of a host processor and connects them to a frame-level CAN protocol engine. Each object carries an identifier (standard 11-bit or extended 29-bit), a direction, a data length code, eight data bytes, interrupt enables and pending/status flags. The host reaches every object through a small word-addressed register port. The protocol engine delivers each received frame as a one-cycle strobe with identifier, format, remote flag, length and payload. The engine is given one pending transmission at a time.

A received frame is compared against the valid objects under a programmable global mask. Data frames go to receive-direction objects. Remote frames go to transmit-direction objects, which then queue their own data frame as a reply. The last object can only receive, and it applies a second mask on top of the global one, so one object can collect a whole group of identifiers. When the host requests transmission on a receive-direction object, a remote frame carrying that object's identifier goes out. An interrupt line summarises all enabled pending flags.

Top module: `can_msg_bank`

## Requirements
- R1: After reset every object is invalid with all flags, lengths, data and identifiers at zero, both masks are zero, tx_req is low and irq is low.
- R2: The register port selects an object with host_obj (1 to 15) and a word with host_field. Field 0 is the identifier: bits 28:0 hold the ID (a standard ID sits in bits 10:0) and bit 29 is the extended flag. Field 1 is control: bit 0 valid, bit 1 transmit direction, bits 5:2 length, bit 6 transmit request, bit 7 receive-interrupt enable, bit 8 transmit-interrupt enable. Field 2 holds data bytes 0 to 3 and field 3 holds bytes 4 to 7, with the lower byte in the lower bits. Field 4 is status: bit 0 receive pending, bit 1 transmit pending, bit 2 new data, bit 3 message lost. Fields 5 and 6 are the global mask and the last object's mask, in bits 28:0, for any host_obj. A write updates state at the next clock edge. host_rdata shows the selected word combinationally, and unused fields or objects read as zero.
- R3: A frame can be taken only by a valid object whose extended flag equals the frame's. For every identifier bit where the global mask is 1, the object's ID must equal the frame's ID. Mask bits of 0 are ignored, and a standard frame compares only bits 10:0.
- R4: Object 15 never takes the transmit direction or a transmit request, and it accepts only data frames. It compares only the bits where both masks are 1. It is considered only when objects 1 to 14 all miss, and when it accepts a frame it stores the received ID.
- R5: When several objects among 1 to 14 match, only the lowest-numbered one takes the frame.
- R6: A data frame taken by an object stores the length and all eight data bytes, and sets new-data and receive-pending.
- R7: If new-data is already set when an object takes a data frame, message-lost is set (and stays set) and the new data overwrites the old.
- R8: A remote frame taken by a transmit-direction object sets its receive-pending flag and its transmit request. The object is then offered as a data frame with its own ID, format, length and data.
- R9: A transmit request on a receive-direction object is offered with tx_rtr high and that object's ID.
- R10: While any request is pending, tx_req is high and tx_obj names the lowest-numbered pending object. That object's request stays set until a tx_done strobe, which clears it and sets its transmit-pending flag.
- R11: irq is high exactly while some object has receive-pending with its receive enable set, or transmit-pending with its transmit enable set.
- R12: Writing field 4 with a bit at 1 clears the matching status flag. Bits at 0 leave flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| host_we | input | 1 | Host write strobe |
| host_obj | input | 4 | Object number, 1 to 15 |
| host_field | input | 3 | Word selector within the object |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected word, combinational |
| rx_valid | input | 1 | One-cycle strobe for a received frame |
| rx_id | input | 29 | Received identifier |
| rx_ide | input | 1 | Received frame uses an extended identifier |
| rx_rtr | input | 1 | Received frame is a remote frame |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received payload, byte 0 in bits 7:0 |
| tx_req | output | 1 | A transmission is offered |
| tx_obj | output | 4 | Number of the offered object, 0 when none |
| tx_id | output | 29 | Identifier to send |
| tx_ide | output | 1 | Extended identifier to send |
| tx_rtr | output | 1 | Send a remote frame |
| tx_dlc | output | 4 | Length code to send |
| tx_data | output | 64 | Payload to send |
| tx_done | input | 1 | Engine reports the offered frame sent |
| irq | output | 1 | Interrupt request |

## Verification
Every stimulus, whether a host write, a received frame or a tx_done strobe, is captured at one rising edge. Its effect on the stored state, on the transmit offer and on irq is due in the same cycle, right after that edge. A read needs no edge: host_rdata follows the selected word in the cycle its address is driven. The bench changes inputs just after a rising edge and compares every output at the following falling edge. A behavioural model updated at each rising edge with the same inputs supplies the expected values, and directed checks with hand-derived values mark the corner cases.

// File: rtl/can_msg_pkg.sv
package can_msg_pkg;
  localparam int ID_W   = 29;
  localparam int STD_W  = 11;
  localparam int DATA_W = 64;
  localparam int REG_W  = 32;
  localparam int DLC_W  = 4;

  localparam logic [2:0] FLD_ID    = 3'd0;
  localparam logic [2:0] FLD_CTRL  = 3'd1;
  localparam logic [2:0] FLD_DLO   = 3'd2;
  localparam logic [2:0] FLD_DHI   = 3'd3;
  localparam logic [2:0] FLD_STAT  = 3'd4;
  localparam logic [2:0] FLD_GMASK = 3'd5;
  localparam logic [2:0] FLD_LMASK = 3'd6;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              ide;
    logic              valid;
    logic              dir_tx;
    logic [DLC_W-1:0]  dlc;
    logic              txrq;
    logic              rxie;
    logic              txie;
    logic              rxip;
    logic              txip;
    logic              newdat;
    logic              msglst;
    logic [DATA_W-1:0] data;
  } obj_t;
endpackage

// File: rtl/cmb_accept.sv
module cmb_accept
  import can_msg_pkg::*;
#(
  parameter int NUM_OBJ = 15,
  localparam int IDX_W  = $clog2(NUM_OBJ)
) (
  input  logic [NUM_OBJ-1:0][ID_W-1:0] obj_id,
  input  logic [NUM_OBJ-1:0]           obj_ide,
  input  logic [NUM_OBJ-1:0]           obj_valid,
  input  logic [NUM_OBJ-1:0]           obj_dir_tx,
  input  logic [ID_W-1:0]              gmask,
  input  logic [ID_W-1:0]              lmask,
  input  logic                         rx_valid,
  input  logic [ID_W-1:0]              rx_id,
  input  logic                         rx_ide,
  input  logic                         rx_rtr,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx
);
  localparam int HI_W = ID_W - STD_W;

  logic [ID_W-1:0]    care_g;
  logic [ID_W-1:0]    care_l;
  logic [NUM_OBJ-1:0] cand;

  always_comb begin
    care_g = rx_ide ? gmask : {{HI_W{1'b0}}, gmask[STD_W-1:0]};
    care_l = care_g & (rx_ide ? lmask : {{HI_W{1'b0}}, lmask[STD_W-1:0]});
  end

  for (genvar gi = 0; gi < NUM_OBJ; gi++) begin : g_obj
    logic same_id;
    logic kind_ok;
    if (gi == NUM_OBJ - 1) begin : g_last
      assign same_id = ((obj_id[gi] ^ rx_id) & care_l) == '0;
      assign kind_ok = !rx_rtr;
    end else begin : g_gen
      assign same_id = ((obj_id[gi] ^ rx_id) & care_g) == '0;
      assign kind_ok = (obj_dir_tx[gi] == rx_rtr);
    end
    assign cand[gi] = rx_valid && obj_valid[gi] && (obj_ide[gi] == rx_ide)
                      && same_id && kind_ok;
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = IDX_W'(NUM_OBJ - 1);
    for (int i = NUM_OBJ - 2; i >= 0; i--) begin
      if (cand[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
    if (!hit && cand[NUM_OBJ-1]) begin
      hit = 1'b1;
    end
  end
endmodule

// File: rtl/cmb_tx_arb.sv
module cmb_tx_arb #(
  parameter int NUM_OBJ = 15,
  localparam int IDX_W  = $clog2(NUM_OBJ)
) (
  input  logic [NUM_OBJ-1:0] pend,
  output logic               req,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    req = |pend;
    idx = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/can_msg_bank.sv
module can_msg_bank
  import can_msg_pkg::*;
#(
  parameter int NUM_OBJ = 15,
  localparam int IDX_W  = $clog2(NUM_OBJ),
  localparam int OBJ_W  = $clog2(NUM_OBJ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [OBJ_W-1:0]  host_obj,
  input  logic [2:0]        host_field,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  input  logic              rx_valid,
  input  logic [ID_W-1:0]   rx_id,
  input  logic              rx_ide,
  input  logic              rx_rtr,
  input  logic [DLC_W-1:0]  rx_dlc,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_req,
  output logic [OBJ_W-1:0]  tx_obj,
  output logic [ID_W-1:0]   tx_id,
  output logic              tx_ide,
  output logic              tx_rtr,
  output logic [DLC_W-1:0]  tx_dlc,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_done,
  output logic              irq
);
  localparam int HALF_W = DATA_W / 2;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  obj_t [NUM_OBJ-1:0] objs_q, objs_d;
  logic [ID_W-1:0]    gmask_q, gmask_d;
  logic [ID_W-1:0]    lmask_q, lmask_d;
  logic               upd_en;

  logic [NUM_OBJ-1:0][ID_W-1:0] v_id;
  logic [NUM_OBJ-1:0]           v_ide, v_valid, v_dir, arb_pend;
  logic                         acc_hit, arb_req;
  logic [IDX_W-1:0]             acc_idx, arb_idx;
  obj_t                         rd_obj, tx_sel;
  logic                         unused_wdata;

  assign unused_wdata = ^host_wdata[REG_W-1:ID_W+1];

  // reset release synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  for (genvar gi = 0; gi < NUM_OBJ; gi++) begin : g_vec
    assign v_id[gi]     = objs_q[gi].id;
    assign v_ide[gi]    = objs_q[gi].ide;
    assign v_valid[gi]  = objs_q[gi].valid;
    assign v_dir[gi]    = objs_q[gi].dir_tx;
    assign arb_pend[gi] = objs_q[gi].txrq;
  end

  cmb_accept #(.NUM_OBJ(NUM_OBJ)) u_accept (
    .obj_id     (v_id),
    .obj_ide    (v_ide),
    .obj_valid  (v_valid),
    .obj_dir_tx (v_dir),
    .gmask      (gmask_q),
    .lmask      (lmask_q),
    .rx_valid   (rx_valid),
    .rx_id      (rx_id),
    .rx_ide     (rx_ide),
    .rx_rtr     (rx_rtr),
    .hit        (acc_hit),
    .hit_idx    (acc_idx)
  );

  cmb_tx_arb #(.NUM_OBJ(NUM_OBJ)) u_tx_arb (
    .pend (arb_pend),
    .req  (arb_req),
    .idx  (arb_idx)
  );

  assign upd_en = host_we | rx_valid | tx_done;

  // next-state
  always_comb begin
    objs_d  = objs_q;
    gmask_d = gmask_q;
    lmask_d = lmask_q;
    for (int i = 0; i < NUM_OBJ; i++) begin
      if (tx_done && arb_req && arb_idx == IDX_W'(i)) begin
        objs_d[i].txrq = 1'b0;
        objs_d[i].txip = 1'b1;
      end
      if (acc_hit && acc_idx == IDX_W'(i)) begin
        objs_d[i].rxip = 1'b1;
        if (rx_rtr) begin
          objs_d[i].txrq = 1'b1;
        end else begin
          objs_d[i].msglst = objs_q[i].msglst | objs_q[i].newdat;
          objs_d[i].newdat = 1'b1;
          objs_d[i].dlc    = rx_dlc;
          objs_d[i].data   = rx_data;
          if (i == NUM_OBJ - 1) objs_d[i].id = rx_id;
        end
      end
      if (host_we && host_obj == OBJ_W'(i + 1)) begin
        case (host_field)
          FLD_ID: begin
            objs_d[i].id  = host_wdata[ID_W-1:0];
            objs_d[i].ide = host_wdata[ID_W];
          end
          FLD_CTRL: begin
            objs_d[i].valid  = host_wdata[0];
            objs_d[i].dir_tx = host_wdata[1] && (i != NUM_OBJ - 1);
            objs_d[i].dlc    = host_wdata[5:2];
            objs_d[i].txrq   = host_wdata[6] && (i != NUM_OBJ - 1);
            objs_d[i].rxie   = host_wdata[7];
            objs_d[i].txie   = host_wdata[8];
          end
          FLD_DLO: objs_d[i].data[HALF_W-1:0]      = host_wdata;
          FLD_DHI: objs_d[i].data[DATA_W-1:HALF_W] = host_wdata;
          FLD_STAT: begin
            objs_d[i].rxip   = objs_d[i].rxip   & ~host_wdata[0];
            objs_d[i].txip   = objs_d[i].txip   & ~host_wdata[1];
            objs_d[i].newdat = objs_d[i].newdat & ~host_wdata[2];
            objs_d[i].msglst = objs_d[i].msglst & ~host_wdata[3];
          end
          default: ;
        endcase
      end
    end
    if (host_we && host_field == FLD_GMASK) gmask_d = host_wdata[ID_W-1:0];
    if (host_we && host_field == FLD_LMASK) lmask_d = host_wdata[ID_W-1:0];
  end

  // state register
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      objs_q  <= '0;
      gmask_q <= '0;
      lmask_q <= '0;
    end else if (upd_en) begin
      objs_q  <= objs_d;
      gmask_q <= gmask_d;
      lmask_q <= lmask_d;
    end
  end

  // host read path
  always_comb begin
    rd_obj = '0;
    for (int i = 0; i < NUM_OBJ; i++) begin
      if (host_obj == OBJ_W'(i + 1)) rd_obj = objs_q[i];
    end
    case (host_field)
      FLD_ID:    host_rdata = REG_W'({rd_obj.ide, rd_obj.id});
      FLD_CTRL:  host_rdata = REG_W'({rd_obj.txie, rd_obj.rxie, rd_obj.txrq,
                                      rd_obj.dlc, rd_obj.dir_tx, rd_obj.valid});
      FLD_DLO:   host_rdata = rd_obj.data[HALF_W-1:0];
      FLD_DHI:   host_rdata = rd_obj.data[DATA_W-1:HALF_W];
      FLD_STAT:  host_rdata = REG_W'({rd_obj.msglst, rd_obj.newdat,
                                      rd_obj.txip, rd_obj.rxip});
      FLD_GMASK: host_rdata = REG_W'(gmask_q);
      FLD_LMASK: host_rdata = REG_W'(lmask_q);
      default:   host_rdata = '0;
    endcase
  end

  // transmit offer and interrupt
  always_comb begin
    tx_sel = '0;
    irq    = 1'b0;
    for (int i = 0; i < NUM_OBJ; i++) begin
      if (arb_idx == IDX_W'(i)) tx_sel = objs_q[i];
      irq = irq | (objs_q[i].rxip & objs_q[i].rxie) | (objs_q[i].txip & objs_q[i].txie);
    end
    tx_req  = arb_req;
    tx_obj  = arb_req ? OBJ_W'(arb_idx) + OBJ_W'(1) : '0;
    tx_id   = tx_sel.id;
    tx_ide  = tx_sel.ide;
    tx_rtr  = !tx_sel.dir_tx;
    tx_dlc  = tx_sel.dlc;
    tx_data = tx_sel.data;
  end
endmodule

// File: rtl/cmb_checker.sv
module cmb_checker #(
  parameter int NUM_OBJ = 15,
  localparam int OBJ_W  = $clog2(NUM_OBJ + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_we,
  input logic               rx_valid,
  input logic               tx_done,
  input logic               tx_req,
  input logic [OBJ_W-1:0]   tx_obj,
  input logic               irq,
  input logic [NUM_OBJ-1:0] pend
);
  logic [NUM_OBJ-1:0] below;

  always_comb begin
    below = '0;
    for (int i = 0; i < NUM_OBJ; i++) begin
      if (OBJ_W'(i + 1) < tx_obj) below[i] = 1'b1;
    end
  end

  assert_no_tx_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> tx_obj != OBJ_W'(NUM_OBJ));

  assert_lowest_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (pend & below) == '0);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_done && !host_we) |=> tx_req);

  assert_pend_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pend) |-> $past(rx_valid || tx_done || host_we));

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(rx_valid || tx_done || host_we));
endmodule

bind can_msg_bank cmb_checker #(.NUM_OBJ(NUM_OBJ)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .host_we  (host_we),
  .rx_valid (rx_valid),
  .tx_done  (tx_done),
  .tx_req   (tx_req),
  .tx_obj   (tx_obj),
  .irq      (irq),
  .pend     (arb_pend)
);

// File: tb/can_msg_bank_bench.sv
`timescale 1ns/1ps
module can_msg_bank_bench;
  localparam int NOBJ = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_obj = '0;
  logic [2:0]  host_field = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        rx_valid = 1'b0;
  logic [28:0] rx_id = '0;
  logic        rx_ide = 1'b0;
  logic        rx_rtr = 1'b0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic        tx_req;
  logic [3:0]  tx_obj;
  logic [28:0] tx_id;
  logic        tx_ide, tx_rtr;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;
  logic        tx_done = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  can_msg_bank u_can_msg_bank (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_obj(host_obj),
    .host_field(host_field), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_ide(rx_ide), .rx_rtr(rx_rtr),
    .rx_dlc(rx_dlc), .rx_data(rx_data), .tx_req(tx_req), .tx_obj(tx_obj),
    .tx_id(tx_id), .tx_ide(tx_ide), .tx_rtr(tx_rtr), .tx_dlc(tx_dlc),
    .tx_data(tx_data), .tx_done(tx_done), .irq(irq)
  );

  // behavioural reference model
  logic [28:0] m_id   [1:NOBJ];
  logic [63:0] m_data [1:NOBJ];
  logic [3:0]  m_dlc  [1:NOBJ];
  logic m_ide[1:NOBJ], m_val[1:NOBJ], m_dir[1:NOBJ], m_txrq[1:NOBJ];
  logic m_rxie[1:NOBJ], m_txie[1:NOBJ], m_rxip[1:NOBJ], m_txip[1:NOBJ];
  logic m_new[1:NOBJ], m_lost[1:NOBJ];
  logic [28:0] m_gm, m_lm;

  task automatic m_reset();
    for (int k = 1; k <= NOBJ; k++) begin
      m_id[k] = '0; m_data[k] = '0; m_dlc[k] = '0; m_ide[k] = 0; m_val[k] = 0;
      m_dir[k] = 0; m_txrq[k] = 0; m_rxie[k] = 0; m_txie[k] = 0; m_rxip[k] = 0;
      m_txip[k] = 0; m_new[k] = 0; m_lost[k] = 0;
    end
    m_gm = '0; m_lm = '0;
  endtask

  function automatic int m_pick();
    for (int k = 1; k <= NOBJ; k++) if (m_txrq[k]) return k;
    return 0;
  endfunction

  function automatic logic m_irq();
    logic r = 0;
    for (int k = 1; k <= NOBJ; k++) r = r | (m_rxip[k] & m_rxie[k]) | (m_txip[k] & m_txie[k]);
    return r;
  endfunction

  function automatic logic [31:0] m_rd(int o, int f);
    if (f == 5) return {3'b0, m_gm};
    if (f == 6) return {3'b0, m_lm};
    if (o < 1 || o > NOBJ) return '0;
    case (f)
      0: return {2'b0, m_ide[o], m_id[o]};
      1: return {23'b0, m_txie[o], m_rxie[o], m_txrq[o], m_dlc[o], m_dir[o], m_val[o]};
      2: return m_data[o][31:0];
      3: return m_data[o][63:32];
      4: return {28'b0, m_lost[o], m_new[o], m_txip[o], m_rxip[o]};
      default: return '0;
    endcase
  endfunction

  task automatic m_step();
    int p;
    int hit;
    int o;
    logic [28:0] cg, cl;
    p = m_pick();
    hit = 0;
    if (tx_done && p != 0) begin m_txrq[p] = 0; m_txip[p] = 1; end
    if (rx_valid) begin
      cg = rx_ide ? m_gm : (m_gm & 29'h7FF);
      cl = cg & m_lm;
      for (int k = 1; k < NOBJ && hit == 0; k++)
        if (m_val[k] && m_ide[k] == rx_ide && ((m_id[k] ^ rx_id) & cg) == 0 && m_dir[k] == rx_rtr)
          hit = k;
      if (hit == 0 && !rx_rtr && m_val[NOBJ] && m_ide[NOBJ] == rx_ide && ((m_id[NOBJ] ^ rx_id) & cl) == 0)
        hit = NOBJ;
      if (hit != 0) begin
        m_rxip[hit] = 1;
        if (rx_rtr) m_txrq[hit] = 1;
        else begin
          m_lost[hit] = m_lost[hit] | m_new[hit];
          m_new[hit] = 1; m_data[hit] = rx_data; m_dlc[hit] = rx_dlc;
          if (hit == NOBJ) m_id[hit] = rx_id;
        end
      end
    end
    if (host_we) begin
      o = int'(host_obj);
      if (host_field == 5) m_gm = host_wdata[28:0];
      else if (host_field == 6) m_lm = host_wdata[28:0];
      else if (o >= 1 && o <= NOBJ) begin
        case (host_field)
          0: begin m_id[o] = host_wdata[28:0]; m_ide[o] = host_wdata[29]; end
          1: begin
            m_val[o] = host_wdata[0]; m_dir[o] = host_wdata[1] && o != NOBJ;
            m_dlc[o] = host_wdata[5:2]; m_txrq[o] = host_wdata[6] && o != NOBJ;
            m_rxie[o] = host_wdata[7]; m_txie[o] = host_wdata[8];
          end
          2: m_data[o][31:0] = host_wdata;
          3: m_data[o][63:32] = host_wdata;
          4: begin
            if (host_wdata[0]) m_rxip[o] = 0;
            if (host_wdata[1]) m_txip[o] = 0;
            if (host_wdata[2]) m_new[o] = 0;
            if (host_wdata[3]) m_lost[o] = 0;
          end
          default: ;
        endcase
      end
    end
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    int p;
    p = m_pick();
    chk("R10 tx_req", 64'(tx_req), 64'(p != 0));
    if (p != 0) begin
      chk("R10 tx_obj", 64'(tx_obj), 64'(p));
      chk("R9 tx_rtr", 64'(tx_rtr), 64'(!m_dir[p]));
      chk("R8 tx_id", 64'(tx_id), 64'(m_id[p]));
      chk("R8 tx_ide", 64'(tx_ide), 64'(m_ide[p]));
      chk("R8 tx_dlc", 64'(tx_dlc), 64'(m_dlc[p]));
      chk("R8 tx_data", tx_data, m_data[p]);
    end
    chk("R11 irq", 64'(irq), 64'(m_irq()));
    chk("R2 host_rdata", 64'(host_rdata), 64'(m_rd(int'(host_obj), int'(host_field))));
  end

  task automatic host_wr(input int o, input int f, input logic [31:0] d);
    @(posedge clk); #1;
    host_we = 1'b1; host_obj = 4'(o); host_field = 3'(f); host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic rx_frame(input logic [28:0] id, input logic ide, input logic rtr,
                          input logic [3:0] dlc, input logic [63:0] d);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_id = id; rx_ide = ide; rx_rtr = rtr; rx_dlc = dlc; rx_data = d;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic tx_ack();
    @(posedge clk); #1; tx_done = 1'b1;
    @(posedge clk); #1; tx_done = 1'b0;
  endtask

  task automatic exp_rd(input int o, input int f, input logic [31:0] exp, input string tag);
    host_obj = 4'(o); host_field = 3'(f);
    @(negedge clk);
    chk(tag, 64'(host_rdata), 64'(exp));
  endtask

  task automatic exp_tx(input logic req, input int o, input logic rtr,
                        input logic [63:0] d, input string tag);
    @(negedge clk);
    chk(tag, 64'(tx_req), 64'(req));
    if (req) begin
      chk(tag, 64'(tx_obj), 64'(o));
      chk(tag, 64'(tx_rtr), 64'(rtr));
      chk(tag, tx_data, d);
    end
  endtask

  task automatic exp_irq(input logic v, input string tag);
    @(negedge clk);
    chk(tag, 64'(irq), 64'(v));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    // R1 reset state
    exp_tx(1'b0, 0, 1'b0, '0, "R1 reset tx_req");
    exp_irq(1'b0, "R1 reset irq");
    exp_rd(1, 1, 32'h0, "R1 reset ctrl");
    exp_rd(1, 5, 32'h0, "R1 reset mask");

    // configuration
    host_wr(1, 5, 32'h1FFF_FFFF);
    host_wr(1, 6, 32'h0000_0700);
    host_wr(1, 0, 32'h123);  host_wr(1, 1, 32'h81);
    host_wr(2, 0, 32'h123);  host_wr(2, 1, 32'h01);
    host_wr(3, 0, 32'h200);  host_wr(3, 2, 32'h0000_BEEF); host_wr(3, 1, 32'h10B);
    host_wr(4, 0, 32'h21AB_CDE0); host_wr(4, 1, 32'h01);
    host_wr(15, 0, 32'h300); host_wr(15, 1, 32'hC3);
    exp_rd(3, 1, 32'h10B, "R2 ctrl readback");
    exp_rd(4, 0, 32'h21AB_CDE0, "R2 ext id readback");
    exp_rd(3, 3, 32'h0, "R2 data high readback");
    exp_rd(15, 1, 32'h81, "R4 last object receive only");
    exp_tx(1'b0, 0, 1'b0, '0, "R4 no request from last object");

    // data frame, two candidates
    rx_frame(29'h123, 1'b0, 1'b0, 4'd4, 64'h0000_0000_1122_3344);
    exp_rd(1, 2, 32'h1122_3344, "R6 data stored");
    exp_rd(1, 4, 32'h5, "R6 rxip and newdat");
    exp_rd(1, 1, 32'h91, "R6 length stored");
    exp_rd(2, 4, 32'h0, "R5 higher object untouched");
    exp_irq(1'b1, "R11 receive interrupt");

    // overwrite before host cleared new data
    rx_frame(29'h123, 1'b0, 1'b0, 4'd4, 64'h0000_0000_5566_7788);
    exp_rd(1, 4, 32'hD, "R7 message lost");
    exp_rd(1, 2, 32'h5566_7788, "R7 new data overwrites");

    // clear flags by writing ones
    host_wr(1, 4, 32'hF);
    exp_rd(1, 4, 32'h0, "R12 status cleared");
    exp_irq(1'b0, "R11 irq drops");

    // format mismatch, then masked match
    rx_frame(29'h123, 1'b1, 1'b0, 4'd1, 64'h1);
    exp_rd(1, 4, 32'h0, "R3 format mismatch ignored");
    exp_rd(4, 4, 32'h0, "R3 id mismatch ignored");
    host_wr(1, 5, 32'h1FFF_FFF0);
    rx_frame(29'h1AB_CDE5, 1'b1, 1'b0, 4'd8, 64'hA5A5_A5A5_0102_0304);
    exp_rd(4, 4, 32'h5, "R3 masked bits ignored");
    exp_rd(4, 3, 32'hA5A5_A5A5, "R6 upper bytes stored");

    // group acceptance by the last object
    rx_frame(29'h345, 1'b0, 1'b0, 4'd1, 64'hAA);
    exp_rd(15, 4, 32'h5, "R4 group accepted");
    exp_rd(15, 0, 32'h345, "R4 received id stored");
    exp_rd(15, 2, 32'hAA, "R4 data stored");
    exp_irq(1'b1, "R11 last object interrupt");
    host_wr(15, 4, 32'hF);
    exp_irq(1'b0, "R12 cleared");

    // remote frame answered automatically
    rx_frame(29'h200, 1'b0, 1'b1, 4'd2, 64'h0);
    exp_tx(1'b1, 3, 1'b0, 64'h0000_BEEF, "R8 automatic reply");
    exp_rd(3, 4, 32'h1, "R8 remote received flag");
    exp_irq(1'b0, "R11 disabled flag no irq");
    tx_ack();
    exp_tx(1'b0, 0, 1'b0, '0, "R10 cleared on done");
    exp_rd(3, 4, 32'h3, "R10 txip set");
    exp_irq(1'b1, "R11 transmit interrupt");
    host_wr(3, 4, 32'h3);

    // remote requests from receive objects, two pending
    host_wr(1, 1, 32'hC1);
    exp_tx(1'b1, 1, 1'b1, 64'h0000_0000_5566_7788, "R9 remote frame request");
    host_wr(2, 1, 32'h41);
    repeat (3) @(posedge clk);
    exp_tx(1'b1, 1, 1'b1, 64'h0000_0000_5566_7788, "R10 lowest held until done");
    tx_ack();
    exp_tx(1'b1, 2, 1'b1, 64'h0, "R10 next object offered");
    exp_rd(1, 4, 32'h2, "R10 txip on first");
    tx_ack();
    exp_tx(1'b0, 0, 1'b0, '0, "R10 queue empty");

    // last object only when the others miss
    host_wr(1, 5, 32'h0);
    rx_frame(29'h305, 1'b0, 1'b0, 4'd1, 64'h77);
    exp_rd(1, 4, 32'h7, "R5 lowest object wins");
    exp_rd(15, 4, 32'h0, "R4 last object skipped");
    repeat (4) @(posedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule